// File: doc/BRIEF.md
# Timer Output Compare Unit

This block is a 16-bit free-running timer with one output compare channel, reached from an 8-bit register bus. A prescaler divides the input clock by four. Each time the prescaler wraps, the counter advances by one. Software programs a 16-bit compare value in two byte writes. When the counter steps onto that value, the unit sets a compare flag and copies a programmed level bit into an output latch that drives a pin. If interrupts are enabled, it also raises an interrupt request.

Two protections keep the byte-wide interface safe. Writing the upper compare byte blocks all matches until the lower byte follows, so a half-updated compare value never fires. Clearing the flag takes two steps: a status read made while the flag is set arms the clear, and a later write to the lower compare byte completes it. Reset leaves the flag and the compare value as they were. A match that coincides with the completing write wins, so that event is not lost.

Register map (address, content): 0 control (bit 0 interrupt enable, bit 1 output level); 1 status (bit 7 compare flag, other bits read 0); 2 compare low byte; 3 compare high byte; 4 counter low byte; 5 counter high byte (read only). Reads have no side effect, except that a status read arms or disarms the clear.

Top module: `oc_timer`

## Requirements
- R1: After reset the counter reads 0xFFFC (address 4 low byte, address 5 high byte). It advances by one on every fourth clock edge after reset release, and wraps from 0xFFFF to 0x0000.
- R2: When the counter steps onto a value equal to the full 16-bit compare value (addresses 2 and 3), status bit 7 is set in the same cycle in which the counter shows that value, and not before.
- R3: A write to the compare high byte (address 3) blocks every match until the compare low byte (address 2) is written. After that write, matches occur again.
- R4: The interrupt request is high exactly when the flag is set and control bit 0 is 1.
- R5: A status read (address 1) made while the flag is set, followed by a write to address 2, clears the flag. A write to address 2 with no such read before it leaves the flag set.
- R6: A status read made while the flag is clear arms nothing. A later write to address 2 does not clear a flag that was set after that read.
- R7: On every match, control bit 1 is copied to the compare output, whether or not the flag is already set.
- R8: The compare output changes only on a match. Writing control bit 1 alone has no effect on it.
- R9: Reset clears the prescaler, control bits 0 and 1, the compare output and the arm state. It leaves the flag and the compare value unchanged.
- R10: When a match and the write that completes the clear fall on the same clock edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| cmp_out | output | 1 | Compare output latch |
| irq | output | 1 | Compare interrupt request |

## Verification
The hardest case to reach from the ports is R10: an armed low-byte write must land on exactly the clock edge where the prescaler wraps and the counter steps onto the compare value. The bench keeps its own count of clock edges since reset release and derives the expected counter value from it. That lets it schedule the write one cycle ahead of the predicted wrap edge, with the flag already set and the clear armed beforehand. The same count also places every match-time sample in the exact cycle, without reading back any internal state.

// File: rtl/oc_timer_pkg.sv
package oc_timer_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP0 = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT0 = 3'd4;
  localparam int CTRL_IE   = 0;
  localparam int CTRL_LVL  = 1;
  localparam int STAT_FLAG = 7;
endpackage

// File: rtl/oc_timer_count.sv
module oc_timer_count #(
  parameter int             CNT_W   = 16,
  parameter int             DIV     = 4,
  parameter logic [CNT_W-1:0] RST_VAL = 16'hFFFC
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_inc
);
  localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick    = (pre_q == PRE_LAST);
    cnt_inc = cnt_q + 1'b1;
    pre_d   = tick ? '0 : pre_q + 1'b1;
    cnt_d   = tick ? cnt_inc : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= RST_VAL;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == $past(cnt) + 1'b1));
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
endmodule

// File: rtl/oc_timer_compare.sv
module oc_timer_compare #(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CNT_W/BUS_W-1:0]  byte_wr,
  input  logic [BUS_W-1:0]        wdata,
  input  logic                    tick,
  input  logic [CNT_W-1:0]        cnt_inc,
  output logic [CNT_W-1:0]        cmp_val,
  output logic                    match
);
  localparam int NB = CNT_W / BUS_W;

  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             inh_q, inh_d;

  always_comb begin
    cmp_d = cmp_q;
    for (int i = 0; i < NB; i++) begin
      if (byte_wr[i]) cmp_d[i*BUS_W +: BUS_W] = wdata;
    end
    if (byte_wr[0])           inh_d = 1'b0;
    else if (byte_wr[NB-1])   inh_d = 1'b1;
    else                      inh_d = inh_q;
  end

  // compare value survives reset: plain register with write enable
  always_ff @(posedge clk) begin
    cmp_q <= cmp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inh_q <= 1'b0;
    else        inh_q <= inh_d;
  end

  assign match   = tick && !inh_q && (cnt_inc == cmp_q);
  assign cmp_val = cmp_q;

  assert_inhibit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_wr[NB-1] && !byte_wr[0]) |=> !match);
endmodule

// File: rtl/oc_timer_flag.sv
module oc_timer_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic stat_rd,
  input  logic clr_wr,
  input  logic ie,
  input  logic level,
  output logic flag,
  output logic cmp_out,
  output logic irq
);
  logic flag_q, flag_d;
  logic arm_q, arm_d;
  logic out_q, out_d;

  always_comb begin
    flag_d = flag_q;
    if (match)                flag_d = 1'b1;
    else if (arm_q && clr_wr) flag_d = 1'b0;

    arm_d = arm_q;
    if (clr_wr && arm_q) arm_d = 1'b0;
    else if (stat_rd)    arm_d = flag_q;

    out_d = match ? level : out_q;
  end

  // flag survives reset
  always_ff @(posedge clk) begin
    flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      arm_q <= arm_d;
      out_q <= out_d;
    end
  end

  assign flag    = flag_q;
  assign cmp_out = out_q;
  assign irq     = ie & flag_q;

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag);
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && clr_wr && !match) |=> !flag);
  assert_noarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !flag) |=> !arm_q);
  assert_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> (cmp_out == $past(level)));
  assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !match |=> $stable(cmp_out));
endmodule

// File: rtl/oc_timer.sv
module oc_timer #(
  parameter int               BUS_W   = 8,
  parameter int               CNT_W   = 16,
  parameter int               DIV     = 4,
  parameter logic [CNT_W-1:0] RST_CNT = 16'hFFFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  input  logic             bus_wr,
  input  logic             bus_rd,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             cmp_out,
  output logic             irq
);
  import oc_timer_pkg::*;
  localparam int NB = CNT_W / BUS_W;

  logic             tick, match, flag;
  logic [CNT_W-1:0] cnt, cnt_inc, cmp_val;
  logic [NB-1:0]    cmp_wr;
  logic             ie_q, ie_d, lvl_q, lvl_d;
  logic             ctrl_wr, stat_rd;

  assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
  assign stat_rd = bus_rd && (bus_addr == A_STAT);

  for (genvar g = 0; g < NB; g++) begin : g_bytes
    assign cmp_wr[g] = bus_wr && (bus_addr == A_CMP0 + ADDR_W'(g));
  end

  always_comb begin
    ie_d  = ctrl_wr ? bus_wdata[CTRL_IE]  : ie_q;
    lvl_d = ctrl_wr ? bus_wdata[CTRL_LVL] : lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      lvl_q <= 1'b0;
    end else begin
      ie_q  <= ie_d;
      lvl_q <= lvl_d;
    end
  end

  oc_timer_count #(.CNT_W(CNT_W), .DIV(DIV), .RST_VAL(RST_CNT)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .cnt_inc(cnt_inc)
  );

  oc_timer_compare #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .byte_wr(cmp_wr), .wdata(bus_wdata),
    .tick(tick), .cnt_inc(cnt_inc), .cmp_val(cmp_val), .match(match)
  );

  oc_timer_flag u_flag (
    .clk(clk), .rst_n(rst_n), .match(match), .stat_rd(stat_rd),
    .clr_wr(cmp_wr[0]), .ie(ie_q), .level(lvl_q),
    .flag(flag), .cmp_out(cmp_out), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL) begin
      bus_rdata[CTRL_IE]  = ie_q;
      bus_rdata[CTRL_LVL] = lvl_q;
    end
    if (bus_addr == A_STAT) bus_rdata[STAT_FLAG] = flag;
    for (int i = 0; i < NB; i++) begin
      if (bus_addr == A_CMP0 + ADDR_W'(i)) bus_rdata = cmp_val[i*BUS_W +: BUS_W];
      if (bus_addr == A_CNT0 + ADDR_W'(i)) bus_rdata = cnt[i*BUS_W +: BUS_W];
    end
  end

  assert_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_q |-> !irq);
  assert_irqset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q && match) |=> irq);
endmodule

// File: tb/sim_oc_timer.sv
`timescale 1ns/1ps
module sim_oc_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] addr;
  logic [7:0] wdata, rdata;
  logic       wr_s, rd_s;
  logic       cmp_out, irq;
  int         total = 0;
  int         bad = 0;
  int         cyc;
  logic [15:0] tgt;
  logic [7:0]  d;

  always #2.5 clk = ~clk;

  oc_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
    .bus_wr(wr_s), .bus_rd(rd_s), .bus_rdata(rdata),
    .cmp_out(cmp_out), .irq(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  function automatic logic [15:0] exp_cnt(input int c);
    return 16'(32'hFFFC + c / 4);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] v);
    addr = a; wdata = v; wr_s = 1'b1;
    @(negedge clk);
    wr_s = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    addr = a; rd_s = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_s = 1'b0;
  endtask

  task automatic set_cmp(input logic [15:0] v);
    wr(3'd3, v[15:8]);
    wr(3'd2, v[7:0]);
  endtask

  task automatic wait_cnt(input logic [15:0] v);
    while (exp_cnt(cyc) != v) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; addr = '0; wdata = '0; wr_s = 1'b0; rd_s = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 / R1 reset state
    check("R9 cmp_out after reset", 16'(cmp_out), 16'h0);
    check("R9 irq after reset", 16'(irq), 16'h0);
    begin int c = cyc; rd(3'd4, d); check("R1 count low at reset", 16'(d), 16'(exp_cnt(c)[7:0])); end
    rd(3'd0, d); check("R9 control after reset", 16'(d), 16'h0);

    // park compare far away and clear any stale flag
    set_cmp(16'h8000);
    rd(3'd1, d);
    wr(3'd2, 8'h00);
    rd(3'd1, d); check("R5 flag clear before tests", 16'(d[7]), 16'h0);

    // R1 sweep across the wrap
    for (int i = 0; i < 40; i++) begin
      int c;
      c = cyc; rd(3'd4, d); check("R1 count low", 16'(d), 16'(exp_cnt(c)[7:0]));
      c = cyc; rd(3'd5, d); check("R1 count high", 16'(d), 16'(exp_cnt(c)[15:8]));
    end

    // R2 R4 R7: match sets flag, irq, output level 1
    wr(3'd0, 8'h03);
    tgt = exp_cnt(cyc) + 16'd6;
    set_cmp(tgt);
    wait_cnt(tgt - 16'd1);
    check("R2 no irq before match", 16'(irq), 16'h0);
    check("R8 output before match", 16'(cmp_out), 16'h0);
    wait_cnt(tgt);
    check("R4 irq at match", 16'(irq), 16'h1);
    check("R7 output takes level 1", 16'(cmp_out), 16'h1);

    // R5: low write without arm keeps flag; read then write clears
    wr(3'd2, tgt[7:0]);
    check("R5 unarmed write keeps flag", 16'(irq), 16'h1);
    rd(3'd1, d); check("R2 status flag set", 16'(d), 16'h80);
    wr(3'd2, tgt[7:0]);
    check("R5 armed write clears flag", 16'(irq), 16'h0);
    rd(3'd1, d); check("R5 status after clear", 16'(d), 16'h00);

    // R6: read with flag clear does not arm
    tgt = exp_cnt(cyc) + 16'd6;
    set_cmp(tgt);
    rd(3'd1, d);
    wait_cnt(tgt);
    check("R2 second match", 16'(irq), 16'h1);
    wr(3'd2, tgt[7:0]);
    check("R6 write after unarmed read keeps flag", 16'(irq), 16'h1);

    // R8: level write alone does nothing; R7: level copied while flag set
    wr(3'd0, 8'h01);
    check("R8 level write no effect", 16'(cmp_out), 16'h1);
    tgt = exp_cnt(cyc) + 16'd6;
    set_cmp(tgt);
    wait_cnt(tgt - 16'd1);
    check("R8 output held before match", 16'(cmp_out), 16'h1);
    wait_cnt(tgt);
    check("R7 level 0 copied with flag set", 16'(cmp_out), 16'h0);
    check("R4 irq stays with flag", 16'(irq), 16'h1);

    // R3: high write blocks matches until low write
    rd(3'd1, d);
    wr(3'd2, tgt[7:0]);
    check("R5 clear before inhibit test", 16'(irq), 16'h0);
    tgt = exp_cnt(cyc) + 16'd6;
    set_cmp(tgt);
    wr(3'd3, tgt[15:8]);
    wait_cnt(tgt + 16'd2);
    check("R3 no match while inhibited", 16'(irq), 16'h0);
    rd(3'd1, d); check("R3 status while inhibited", 16'(d), 16'h00);
    tgt = exp_cnt(cyc) + 16'd6;
    set_cmp(tgt);
    wait_cnt(tgt);
    check("R3 match after low write", 16'(irq), 16'h1);

    // R10: armed clear on the match edge
    tgt = exp_cnt(cyc) + 16'd8;
    set_cmp(tgt);
    rd(3'd1, d); check("R10 flag set before collision", 16'(d), 16'h80);
    while (!(((cyc + 1) % 4 == 0) && (exp_cnt(cyc + 1) == tgt))) @(negedge clk);
    wr(3'd2, tgt[7:0]);
    check("R10 count at collision", exp_cnt(cyc), tgt);
    check("R10 flag kept on collision", 16'(irq), 16'h1);
    rd(3'd1, d);
    wr(3'd2, tgt[7:0]);
    check("R5 clear after collision", 16'(irq), 16'h0);

    // R9: reset keeps flag and compare value
    wr(3'd0, 8'h03);
    tgt = exp_cnt(cyc) + 16'd6;
    set_cmp(tgt);
    wait_cnt(tgt);
    check("R7 output level 1 before reset", 16'(cmp_out), 16'h1);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R9 output cleared by reset", 16'(cmp_out), 16'h0);
    check("R9 irq low with enable cleared", 16'(irq), 16'h0);
    begin int c = cyc; rd(3'd4, d); check("R1 count restarts", 16'(d), 16'(exp_cnt(c)[7:0])); end
    rd(3'd0, d); check("R9 control cleared", 16'(d), 16'h0);
    rd(3'd1, d); check("R9 flag retained", 16'(d), 16'h80);
    rd(3'd2, d); check("R9 compare low retained", 16'(d), 16'(tgt[7:0]));
    rd(3'd3, d); check("R9 compare high retained", 16'(d), 16'(tgt[15:8]));
    wr(3'd2, tgt[7:0]);
    rd(3'd1, d); check("R5 clear after reset", 16'(d), 16'h00);

    finish_run();
  end
endmodule